// File: doc/BRIEF.md
# Three-Lane Block-Parallel FIR Filter

This block is a three-tap FIR filter, y(n) = a·x(n) + b·x(n−1) + c·x(n−2), built to run at one third of the sample rate. Each clock it takes a group of three consecutive samples and returns a group of three filtered results. Lane 0 carries the oldest sample of the group, x(3k). Lane 1 carries x(3k+1) and lane 2 carries x(3k+2).

The two newest samples of each accepted group are kept in history registers. The next group uses them as x(3k−2) and x(3k−1), so lane 0 and lane 1 can form their terms that cross the group boundary. The coefficients are inputs and are used in the same cycle as the group they arrive with. Products and sums keep full precision: 16-bit signed samples, 16-bit signed coefficients and 34-bit signed results, with no rounding. The result register adds one cycle of latency. A parameter can add further output pipeline stages.

Top module: `fir3p_filter`

## Requirements
- R1: In the cycle after an accepted group (in_valid high), out_y[0] equals a·x(3k) + b·x(3k−1) + c·x(3k−2). Here x(3k) is in_samples[0], and x(3k−1) and x(3k−2) are in_samples[2] and in_samples[1] of the previous accepted group.
- R2: out_y[1] equals a·x(3k+1) + b·x(3k) + c·x(3k−1), where x(3k+1) is in_samples[1].
- R3: out_y[2] equals a·x(3k+2) + b·x(3k+1) + c·x(3k), where x(3k+2) is in_samples[2].
- R4: The history is updated only by groups with in_valid high. Samples presented while in_valid is low have no effect on any later result.
- R5: While rst (synchronous, active high) is asserted, and in the cycles after it until the first accepted group has produced its result, out_valid is 0 and every out_y lane is 0. The first group after reset sees x(3k−1) = x(3k−2) = 0.
- R6: With the default OUT_STAGES = 0, out_valid is high in exactly the cycle after each accepted group. Each input group produces exactly one output group.
- R7: Results are exact 34-bit signed two's-complement values. With all samples and all coefficients at −32768, every lane gives 3·2^30 = 3221225472, with no wrap and no saturation.
- R8: While out_valid is low, out_y keeps the value of the last valid output group.
- R9: coef_a, coef_b and coef_c are applied to the group presented in the same cycle. A change between two groups affects only the later group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The sample group on in_samples is to be accepted |
| in_samples | input | 3x16 | Signed samples; index 0 is x(3k), index 2 is x(3k+2) |
| coef_a | input | 16 | Signed weight on x(n) |
| coef_b | input | 16 | Signed weight on x(n−1) |
| coef_c | input | 16 | Signed weight on x(n−2) |
| out_valid | output | 1 | out_y holds a new result group |
| out_y | output | 3x34 | Signed results; index i matches input lane i |

## Verification
The bench places impulses in each lane. A design that wires the lanes wrongly, or that picks the wrong history sample, then shows a misplaced or missing tap in lane 0 or lane 1 of the following group. Idle cycles carry random garbage on the sample inputs; a history that loads without checking the valid bit passes that garbage into the next real group. Groups at the extremes of the range (−32768 on every sample and coefficient) expose a sum that is too narrow or a product whose sign is not extended, because the expected result is 3·2^30. Coefficient changes from one group to the next, a reset in the middle of the run, and long random runs with gaps catch a weight that is sampled late, a history that is not cleared, and a valid output that is lost or repeated.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int GUARD_W  = 2;
    localparam int ACC_W    = SAMPLE_W + COEF_W + GUARD_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        coef_t w_now;
        coef_t w_d1;
        coef_t w_d2;
    } coef_set_t;

    typedef struct packed {
        sample_t older;
        sample_t newer;
    } hist_t;

    function automatic acc_t tap3(coef_set_t k, sample_t x_now, sample_t x_d1, sample_t x_d2);
        acc_t p0;
        acc_t p1;
        acc_t p2;
        p0 = acc_t'(k.w_now) * acc_t'(x_now);
        p1 = acc_t'(k.w_d1)  * acc_t'(x_d1);
        p2 = acc_t'(k.w_d2)  * acc_t'(x_d2);
        return p0 + p1 + p2;
    endfunction

endpackage

// File: rtl/fir3p_history.sv
module fir3p_history
    import fir3p_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  grp_valid,
    input  sample_t [LANES-1:0]   lanes,
    output hist_t                 hist
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (grp_valid) begin
            hist.older <= lanes[LANES-2];
            hist.newer <= lanes[LANES-1];
        end
    end

    // R5: history is zero right after a reset cycle
    a_r5_hist_cleared: assert property (@(posedge clk) $past(rst) |-> (hist == '0));

    // R4: no accepted group, no history change
    a_r4_hist_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(grp_valid) && !$past(rst)) |-> $stable(hist));

endmodule

// File: rtl/fir3p_lanes.sv
module fir3p_lanes
    import fir3p_pkg::*;
#(
    parameter int LANES = 3
) (
    input  sample_t [LANES-1:0] lanes,
    input  hist_t               hist,
    input  coef_set_t           coefs,
    output acc_t    [LANES-1:0] sums
);

    localparam int EXT_N = LANES + 2;

    // ext[j] holds x(L*k - 2 + j)
    sample_t ext [EXT_N];

    assign ext[0] = hist.older;
    assign ext[1] = hist.newer;

    for (genvar j = 0; j < LANES; j++) begin : g_ext
        assign ext[j+2] = lanes[j];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_mac
        assign sums[i] = tap3(coefs, ext[i+2], ext[i+1], ext[i]);
    end

endmodule

// File: rtl/fir3p_stage.sv
module fir3p_stage
    import fir3p_pkg::*;
#(
    parameter int LANES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vld_d,
    input  acc_t [LANES-1:0]   data_d,
    output logic               vld_q,
    output acc_t [LANES-1:0]   data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            vld_q <= vld_d;
            if (vld_d) begin
                data_q <= data_d;
            end
        end
    end

    // R8: data held when nothing valid arrives
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !vld_d |=> $stable(data_q));

endmodule

// File: rtl/fir3p_filter.sv
module fir3p_filter
    import fir3p_pkg::*;
#(
    parameter int LANES      = 3,
    parameter int OUT_STAGES = 0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [LANES-1:0][SAMPLE_W-1:0]     in_samples,
    input  logic signed [COEF_W-1:0]           coef_a,
    input  logic signed [COEF_W-1:0]           coef_b,
    input  logic signed [COEF_W-1:0]           coef_c,
    output logic                               out_valid,
    output logic [LANES-1:0][ACC_W-1:0]        out_y
);

    localparam int CHAIN_N = OUT_STAGES + 2;

    sample_t [LANES-1:0] lanes;
    hist_t               hist;
    coef_set_t           coefs;
    acc_t    [LANES-1:0] sums;

    assign lanes       = in_samples;
    assign coefs.w_now = coef_a;
    assign coefs.w_d1  = coef_b;
    assign coefs.w_d2  = coef_c;

    fir3p_history #(.LANES(LANES)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .grp_valid (in_valid),
        .lanes     (lanes),
        .hist      (hist)
    );

    fir3p_lanes #(.LANES(LANES)) u_lanes (
        .lanes (lanes),
        .hist  (hist),
        .coefs (coefs),
        .sums  (sums)
    );

    logic               chain_v [CHAIN_N];
    acc_t [LANES-1:0]   chain_d [CHAIN_N];

    assign chain_v[0] = in_valid;
    assign chain_d[0] = sums;

    for (genvar s = 0; s <= OUT_STAGES; s++) begin : g_stage
        fir3p_stage #(.LANES(LANES)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .vld_d  (chain_v[s]),
            .data_d (chain_d[s]),
            .vld_q  (chain_v[s+1]),
            .data_q (chain_d[s+1])
        );
    end

    assign out_valid = chain_v[CHAIN_N-1];
    assign out_y     = chain_d[CHAIN_N-1];

    if (OUT_STAGES == 0) begin : g_lat_chk
        // R6: one output group the cycle after each accepted group
        a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (out_valid == $past(in_valid)));
    end

endmodule

// File: tb/fir3p_filter_bench.sv
module fir3p_filter_bench;

    localparam int L  = 3;
    localparam int AW = 34;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic [L-1:0][15:0]   in_samples;
    logic signed [15:0]   coef_a, coef_b, coef_c;
    logic                 out_valid;
    logic [L-1:0][AW-1:0] out_y;

    always #10 clk = ~clk;

    fir3p_filter u_fir3p_filter (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .coef_a     (coef_a),
        .coef_b     (coef_b),
        .coef_c     (coef_c),
        .out_valid  (out_valid),
        .out_y      (out_y)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    longint exp0_q[$];
    longint exp1_q[$];
    longint exp2_q[$];
    string  note_q[$];

    longint h_d1 = 0;   // x(3k-1)
    longint h_d2 = 0;   // x(3k-2)
    longint last_y [L];
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint lane_val(input int i);
        logic signed [AW-1:0] v;
        v = out_y[i];
        return longint'(v);
    endfunction

    task automatic send(input int x0, input int x1, input int x2,
                        input int a, input int b, input int c, input string note);
        @(negedge clk);
        in_valid      = 1'b1;
        in_samples[0] = 16'(x0);
        in_samples[1] = 16'(x1);
        in_samples[2] = 16'(x2);
        coef_a = 16'(a);
        coef_b = 16'(b);
        coef_c = 16'(c);
        exp0_q.push_back(longint'(a)*x0 + longint'(b)*h_d1 + longint'(c)*h_d2);
        exp1_q.push_back(longint'(a)*x1 + longint'(b)*x0   + longint'(c)*h_d1);
        exp2_q.push_back(longint'(a)*x2 + longint'(b)*x1   + longint'(c)*x0);
        note_q.push_back(note);
        h_d2 = x1;
        h_d1 = x2;
    endtask

    function automatic int rnd16();
        logic signed [15:0] r;
        seed = seed * 32'd1103515245 + 32'd12345;
        r = seed[30:15];
        return int'(r);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid      = 1'b0;
            in_samples[0] = 16'(rnd16());
            in_samples[1] = 16'(rnd16());
            in_samples[2] = 16'(rnd16());
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp0_q.size() == 0) begin
                    chk("R6 unexpected out_valid", 1, 0);
                end else begin
                    string nt;
                    nt = note_q.pop_front();
                    chk({"R1 lane0 ", nt}, lane_val(0), exp0_q.pop_front());
                    chk({"R2 lane1 ", nt}, lane_val(1), exp1_q.pop_front());
                    chk({"R3 lane2 ", nt}, lane_val(2), exp2_q.pop_front());
                end
                for (int i = 0; i < L; i++) last_y[i] = lane_val(i);
            end else begin
                for (int i = 0; i < L; i++) chk("R8 hold while idle", lane_val(i), last_y[i]);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 out_valid in reset", longint'(out_valid), 0);
        for (int i = 0; i < L; i++) chk("R5 out_y in reset", lane_val(i), 0);
        h_d1 = 0;
        h_d2 = 0;
        for (int i = 0; i < L; i++) last_y[i] = 0;
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_samples = '0;
        coef_a = 0; coef_b = 0; coef_c = 0;
        for (int i = 0; i < L; i++) last_y[i] = 0;
        do_reset();

        // impulses walk across lanes and the group boundary (R1..R3, R5 zero history)
        send(1, 0, 0, 1, 2, 3, "R5 first group zero history");
        send(0, 1, 0, 1, 2, 3, "impulse lane1");
        send(0, 0, 1, 1, 2, 3, "impulse lane2");
        send(0, 0, 0, 1, 2, 3, "R1 R2 cross boundary");
        send(5, -7, 9, 3, -4, 11, "mixed");

        // idle with garbage, then continue (R4, R8)
        idle(3);
        send(2, 4, 6, 1, 1, 1, "R4 after gap");
        idle(1);

        // coefficient change per group (R9)
        send(100, -200, 300, 1, 0, 0, "R9 coef set 1");
        send(-50, 60, -70, 0, 1, 0, "R9 coef set 2");
        send(11, 22, 33, 0, 0, 1, "R9 coef set 3");

        // extremes (R7)
        send(-32768, -32768, -32768, -32768, -32768, -32768, "R7 min all");
        send(-32768, -32768, -32768, -32768, -32768, -32768, "R7 min all again");
        send(32767, 32767, 32767, -32768, -32768, -32768, "R7 max x neg coef");
        send(32767, -32768, 32767, 32767, 32767, 32767, "R7 alternating");

        // random runs with occasional gaps
        for (int g = 0; g < 40; g++) begin
            int a, b, c;
            a = rnd16(); b = rnd16(); c = rnd16();
            send(rnd16(), rnd16(), rnd16(), a, b, c, "random");
            if (g % 7 == 3) idle(2);
        end

        // mid-run reset clears history (R5)
        idle(2);
        do_reset();
        send(3, 4, 5, 10, 20, 30, "R5 after mid reset");
        idle(3);

        chk("R6 all groups produced", longint'(exp0_q.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule